// File: doc/BRIEF.md
# Root Contention Resolver

This block is the per-node controller that settles which of two directly connected nodes becomes root when both try to claim that role at the same moment. It drives three single-cycle line strobes towards its peer (idle, request and acknowledge) and receives the same three strobes back. On contention it announces idle and picks a fast or slow back-off window from an internal pseudo-random source. It then waits on a tick-driven timer, reacting to what the peer signals in the meantime, and ends either as root or as child.

A node that finishes its window while it knows the peer is requesting becomes root and sends an acknowledge. A node that finishes its window after seeing the peer go idle sends a request instead. It becomes child if that request is acknowledged, and it returns to contention if it is answered by a request. The link medium and tree identification above this step belong to other blocks. The `tick` input is the time base: the timer moves only on cycles where `tick` is high.

Top module: `rcr_resolver`

## Requirements
- R1: During and right after reset the controller sits in the contention state with `txIdle`, `txReq`, `txAck`, `isRoot` and `isChild` all low, the timer at 0 and the random register at its seed (default 16'hACE1).
- R2: In contention with `rxIdle` low, the next clock edge raises `txIdle` for one cycle and enters a request-seen window. The window is slow when bit 0 of the random register is 1 and fast when it is 0. The random register is a 16-bit right-shifting Galois LFSR with feedback mask 16'hB400, and it advances exactly once per choice.
- R3: `rxIdle` in contention moves to a received-idle state without driving anything. There, `rxReq` returns the node to contention. Without `rxReq`, the node raises `txIdle` on the next edge and enters an idle window whose speed is chosen as in R2.
- R4: In a request-seen window with `tick` held high, `txAck` pulses exactly MIN+1 cycles after the `txIdle` pulse (MIN is 76 for fast, 159 for slow), and `isRoot` rises on the same edge.
- R5: In an idle window the node leaves at the same count with a `txReq` pulse instead. If `rxReq` arrives first, the node switches to the request-seen window of the same speed and keeps the timer.
- R6: The timer advances only on cycles where `tick` is high. It never exceeds the active window maximum (85 fast, 167 slow) and never exceeds 168.
- R7: After sending a request, the node returns to contention on `rxReq`, so `txIdle` follows two edges later. On `rxAck` it becomes child. With neither, it waits indefinitely with all outputs low.
- R8: Root and child are held until reset and are never both high. While either is held, all receive inputs are ignored and no strobe is driven.
- R9: `rxIdle` in a request-seen window moves the node to the idle window of the same speed and keeps the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base enable for the back-off timer |
| rxIdle | input | 1 | Idle strobe received from the peer |
| rxReq | input | 1 | Request strobe received from the peer |
| rxAck | input | 1 | Acknowledge strobe received from the peer |
| txIdle | output | 1 | Idle strobe sent to the peer |
| txReq | output | 1 | Request strobe sent to the peer |
| txAck | output | 1 | Acknowledge strobe sent to the peer |
| isRoot | output | 1 | Node has resolved as root |
| isChild | output | 1 | Node has resolved as child |

## Verification
The main function is tried with four peer patterns: a silent peer, a peer that goes idle just after our idle, a peer that goes idle and then requests, and a peer that answers our request with a request so that contention repeats. The silent peer separates the root path from the child path. The idle peer shows that the timer survives a window switch. The repeated-contention rows show that successive fast/slow picks follow the stated LFSR sequence, because each pick's latency (77 or 160 cycles) tells the two windows apart. Directed cases pause `tick`, leave a request unanswered for hundreds of cycles, and drive all receive lines after an outcome is reached.

// File: rtl/rcr_pkg.sv
`timescale 1ns/1ps
package rcr_pkg;
  typedef enum logic [3:0] {
    ST_CONTEND, ST_GOT_IDLE, ST_REQ_FAST, ST_REQ_SLOW,
    ST_IDLE_FAST, ST_IDLE_SLOW, ST_SEND_REQ, ST_ROOT, ST_CHILD
  } rcr_state_e;

  typedef struct packed {
    logic clrTimer;
    logic countEn;
    logic stepLfsr;
  } rcr_strobe_t;
endpackage

// File: rtl/rcr_datapath.sv
`timescale 1ns/1ps
module rcr_datapath
  import rcr_pkg::*;
#(
  parameter int TIMER_CAP = 168,
  parameter int LW = 16,
  parameter logic [LW-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [LW-1:0] LFSR_MASK = 16'hB400,
  localparam int TW = $clog2(TIMER_CAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rcr_strobe_t   strobe,
  output logic [TW-1:0] timerVal,
  output logic          slowPick
);
  logic [LW-1:0] lfsr;

  always_ff @(posedge clk) begin
    if (!rst_n) timerVal <= '0;
    else if (strobe.clrTimer) timerVal <= '0;
    else if (strobe.countEn && (timerVal < TW'(TIMER_CAP))) timerVal <= timerVal + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= LFSR_SEED;
    else if (strobe.stepLfsr) lfsr <= {1'b0, lfsr[LW-1:1]} ^ (lfsr[0] ? LFSR_MASK : '0);
  end

  assign slowPick = lfsr[0];

  assert_timer_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timerVal <= TW'(TIMER_CAP));
  assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
  assert_lfsr_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.stepLfsr |=> $stable(lfsr));
endmodule

// File: rtl/rcr_control.sv
`timescale 1ns/1ps
module rcr_control
  import rcr_pkg::*;
#(
  parameter int FAST_MIN = 76,
  parameter int FAST_MAX = 85,
  parameter int SLOW_MIN = 159,
  parameter int SLOW_MAX = 167,
  parameter int TIMER_CAP = 168,
  localparam int TW = $clog2(TIMER_CAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxIdle,
  input  logic          rxReq,
  input  logic          rxAck,
  input  logic [TW-1:0] timerVal,
  input  logic          slowPick,
  output rcr_strobe_t   strobe,
  output logic          txIdle,
  output logic          txReq,
  output logic          txAck,
  output logic          isRoot,
  output logic          isChild
);
  rcr_state_e state, nextState;
  logic sendIdle, sendReq, sendAck, inWindow, slowWin;
  logic [TW-1:0] winMin, winMax;

  assign slowWin  = (state == ST_REQ_SLOW) || (state == ST_IDLE_SLOW);
  assign inWindow = slowWin || (state == ST_REQ_FAST) || (state == ST_IDLE_FAST);
  assign winMin   = slowWin ? TW'(SLOW_MIN) : TW'(FAST_MIN);
  assign winMax   = slowWin ? TW'(SLOW_MAX) : TW'(FAST_MAX);

  always_comb begin
    nextState = state;
    sendIdle = 1'b0;
    sendReq = 1'b0;
    sendAck = 1'b0;
    strobe.clrTimer = 1'b0;
    strobe.stepLfsr = 1'b0;
    strobe.countEn = tick && inWindow && (timerVal < winMax);
    case (state)
      ST_CONTEND:
        if (rxIdle) nextState = ST_GOT_IDLE;
        else begin
          sendIdle = 1'b1;
          strobe.stepLfsr = 1'b1;
          strobe.clrTimer = 1'b1;
          nextState = slowPick ? ST_REQ_SLOW : ST_REQ_FAST;
        end
      ST_GOT_IDLE:
        if (rxReq) nextState = ST_CONTEND;
        else begin
          sendIdle = 1'b1;
          strobe.stepLfsr = 1'b1;
          strobe.clrTimer = 1'b1;
          nextState = slowPick ? ST_IDLE_SLOW : ST_IDLE_FAST;
        end
      ST_REQ_FAST, ST_REQ_SLOW:
        if (rxIdle) nextState = slowWin ? ST_IDLE_SLOW : ST_IDLE_FAST;
        else if (timerVal >= winMin) begin
          sendAck = 1'b1;
          strobe.clrTimer = 1'b1;
          nextState = ST_ROOT;
        end
      ST_IDLE_FAST, ST_IDLE_SLOW:
        if (rxReq) nextState = slowWin ? ST_REQ_SLOW : ST_REQ_FAST;
        else if (timerVal >= winMin) begin
          sendReq = 1'b1;
          strobe.clrTimer = 1'b1;
          nextState = ST_SEND_REQ;
        end
      ST_SEND_REQ:
        if (rxReq) nextState = ST_CONTEND;
        else if (rxAck) nextState = ST_CHILD;
      default: nextState = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_CONTEND;
      txIdle <= 1'b0;
      txReq <= 1'b0;
      txAck <= 1'b0;
    end else begin
      state <= nextState;
      txIdle <= sendIdle;
      txReq <= sendReq;
      txAck <= sendAck;
    end
  end

  assign isRoot  = (state == ST_ROOT);
  assign isChild = (state == ST_CHILD);

  assert_outcome_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({isRoot, isChild}));
  assert_root_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    isRoot |=> isRoot && !txIdle && !txReq && !txAck);
  assert_child_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    isChild |=> isChild && !txIdle && !txReq && !txAck);
  assert_tx_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({txIdle, txReq, txAck}));
  assert_root_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isRoot) |-> txAck);
  assert_fast_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ_FAST || state == ST_IDLE_FAST) |-> timerVal <= TW'(FAST_MAX));
  assert_slow_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slowWin |-> timerVal <= TW'(SLOW_MAX));
  assert_tick_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && inWindow && !strobe.clrTimer) |=> timerVal == $past(timerVal));
  assert_ack_to_child_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND_REQ && !rxReq && rxAck) |=> isChild);
endmodule

// File: rtl/rcr_resolver.sv
`timescale 1ns/1ps
module rcr_resolver
  import rcr_pkg::*;
#(
  parameter int FAST_MIN = 76,
  parameter int FAST_MAX = 85,
  parameter int SLOW_MIN = 159,
  parameter int SLOW_MAX = 167,
  parameter int TIMER_CAP = 168,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxIdle,
  input  logic rxReq,
  input  logic rxAck,
  output logic txIdle,
  output logic txReq,
  output logic txAck,
  output logic isRoot,
  output logic isChild
);
  localparam int TW = $clog2(TIMER_CAP + 1);

  rcr_strobe_t strobe;
  logic [TW-1:0] timerVal;
  logic slowPick;

  rcr_datapath #(.TIMER_CAP(TIMER_CAP), .LW(16), .LFSR_SEED(LFSR_SEED),
                 .LFSR_MASK(16'hB400)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .timerVal(timerVal), .slowPick(slowPick));

  rcr_control #(.FAST_MIN(FAST_MIN), .FAST_MAX(FAST_MAX), .SLOW_MIN(SLOW_MIN),
                .SLOW_MAX(SLOW_MAX), .TIMER_CAP(TIMER_CAP)) u_ctl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxIdle(rxIdle), .rxReq(rxReq),
    .rxAck(rxAck), .timerVal(timerVal), .slowPick(slowPick), .strobe(strobe),
    .txIdle(txIdle), .txReq(txReq), .txAck(txAck), .isRoot(isRoot),
    .isChild(isChild));
endmodule

// File: tb/test_rcr_resolver.sv
`timescale 1ns/1ps
module test_rcr_resolver;
  localparam int FMIN = 76;
  localparam int SMIN = 159;
  localparam logic [15:0] SEED = 16'hACE1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1, rxIdle = 1'b0, rxReq = 1'b0, rxAck = 1'b0;
  logic txIdle, txReq, txAck, isRoot, isChild;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] mdl;

  always #2 clk = ~clk;

  rcr_resolver i_rcr_resolver (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxIdle(rxIdle), .rxReq(rxReq),
    .rxAck(rxAck), .txIdle(txIdle), .txReq(txReq), .txAck(txAck),
    .isRoot(isRoot), .isChild(isChild));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  // Table rows: {resetBefore, peerIdle, reply[1:0]}; reply 0 = ack, 1 = request
  localparam int NROW = 5;
  localparam logic [3:0] ROWS [NROW] = '{4'b1101, 4'b0101, 4'b0000, 4'b1000, 4'b1100};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic bit modelPick();
    bit s = mdl[0];
    mdl = {1'b0, mdl[15:1]} ^ (mdl[0] ? 16'hB400 : 16'h0000);
    return s;
  endfunction

  task automatic doReset();
    rst_n = 1'b0; rxIdle = 0; rxReq = 0; rxAck = 0; tick = 1;
    repeat (3) step();
    check({txIdle, txReq, txAck, isRoot, isChild} == 5'b0, "R1 outputs in reset",
          {txIdle, txReq, txAck, isRoot, isChild}, 0);
    rst_n = 1'b1;
    mdl = SEED;
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    do begin step(); n++; end while (!txIdle && n < 10);
    check(txIdle == 1'b1, tag, n, 1);
  endtask

  task automatic waitOut(input int start, output int n);
    n = start;
    do begin step(); n++; end while (!txAck && !txReq && n < 1000);
  endtask

  initial begin
    int n;
    int expLat;
    bit slow;
    bit anyOut;
    // ---------------- table walk ----------------
    for (int r = 0; r < NROW; r++) begin
      if (ROWS[r][3]) doReset();
      waitIdle("R2 idle after contention");
      slow = modelPick();
      expLat = (slow ? SMIN : FMIN) + 1;
      n = 0;
      if (ROWS[r][2]) begin
        rxIdle = 1; step(); rxIdle = 0; n = 1;
      end
      waitOut(n, n);
      check(n == expLat, "R4/R9 window latency and LFSR pick (R2)", n, expLat);
      if (ROWS[r][2]) begin
        check(txReq == 1'b1, "R9 idle window ends in request", txReq, 1);
        if (ROWS[r][1:0] == 2'd0) begin
          rxAck = 1; step(); rxAck = 0;
          check(isChild && !isRoot, "R7 ack makes child", isChild, 1);
        end else begin
          rxReq = 1; step(); rxReq = 0;
          check(!txIdle && !isRoot && !isChild, "R7 request returns to contention",
                txIdle, 0);
        end
      end else begin
        check(txAck && isRoot, "R4 root with ack", {txAck, isRoot}, 3);
      end
    end

    // ---------------- R3: idle then request in contention ----------------
    doReset();
    rxIdle = 1; step(); rxIdle = 0;
    check(txIdle == 1'b0, "R3 no idle sent on received idle", txIdle, 0);
    rxReq = 1; step(); rxReq = 0;
    check(txIdle == 1'b0, "R3 request returns to contention", txIdle, 0);
    step();
    check(txIdle == 1'b1, "R3 idle sent after re-contention", txIdle, 1);
    slow = modelPick();
    waitOut(0, n);
    expLat = (slow ? SMIN : FMIN) + 1;
    check(n == expLat && txAck, "R3 re-contention ends as root", n, expLat);

    // ---------------- R3 received-idle path, R7 waiting ----------------
    doReset();
    rxIdle = 1; step(); rxIdle = 0;
    step();
    check(txIdle == 1'b1, "R3 idle sent from received-idle", txIdle, 1);
    slow = modelPick();
    waitOut(0, n);
    expLat = (slow ? SMIN : FMIN) + 1;
    check(n == expLat && txReq, "R3 received-idle enters idle window", n, expLat);
    anyOut = 0;
    repeat (300) begin
      step();
      if (txIdle || txReq || txAck || isRoot || isChild) anyOut = 1;
    end
    check(!anyOut, "R7 waits with no reply", anyOut, 0);
    rxAck = 1; step(); rxAck = 0;
    check(isChild == 1'b1, "R7 late ack makes child", isChild, 1);

    // ---------------- R5: request in idle window ----------------
    doReset();
    waitIdle("R2 idle after reset");
    slow = modelPick();
    rxIdle = 1; step(); rxIdle = 0;
    repeat (3) step();
    rxReq = 1; step(); rxReq = 0;
    waitOut(5, n);
    expLat = (slow ? SMIN : FMIN) + 1;
    check(n == expLat, "R5 timer kept across switch", n, expLat);
    check(txAck && isRoot, "R5 request in idle window leads to root", {txAck, isRoot}, 3);

    // ---------------- R6: tick gating ----------------
    doReset();
    waitIdle("R2 idle after reset");
    slow = modelPick();
    tick = 0;
    repeat (40) step();
    tick = 1;
    waitOut(40, n);
    expLat = (slow ? SMIN : FMIN) + 41;
    check(n == expLat, "R6 timer frozen while tick low", n, expLat);

    // ---------------- R8: outcome held, inputs ignored ----------------
    rxIdle = 1; rxReq = 1; rxAck = 1;
    anyOut = 0;
    repeat (20) begin
      step();
      if (txIdle || txReq || txAck || !isRoot || isChild) anyOut = 1;
    end
    rxIdle = 0; rxReq = 0; rxAck = 0;
    check(!anyOut, "R8 root held, inputs ignored", anyOut, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule